// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block arbitrates eight interrupt request lines toward a processor. A rising edge on a request line latches a pending bit. A fixed-priority resolver, with line 0 highest, picks among the pending bits that are not masked. When a winner exists, the block raises an interrupt output. The processor answers with a two-pulse acknowledge. The first pulse moves the winning level from pending into service. The second pulse returns a vector made from a programmable base and the level number.

Software controls the block through a small write port that takes four word kinds:
- a mask word;
- an end-of-service command, either non-specific or naming one level;
- a mode word that turns special masking on or off;
- a configuration word holding the vector base and the automatic end-of-service enable.

The automatic end-of-service option retires the serviced level without software when the acknowledge finishes. Only an instance built in the master role honours it.

In normal operation, a level in service holds off its own level and every lower level. Special masking removes that hold-off, so that any unmasked level can be granted. It also makes the non-specific end-of-service command pass over levels whose mask bit is set. A master instance normally receives the slave's request on line 2, so masking level 2 silences the whole slave.

Top module: `prio_intc`

## Requirements
- R1: After reset the interrupt output and vector valid are low, all eight mask bits are set, no level is pending or in service, special masking and automatic end-of-service are off, and the vector base is zero.
- R2: A rising edge on request line i sets pending bit i, which stays set after the line falls. The interrupt output rises one clock after the edge when that level is unmasked and not held off.
- R3: The lowest-numbered eligible level wins. The rising edge of the first acknowledge pulse puts it in service and clears its pending bit. The rising edge of the second pulse drives vector_out = {base, level} with vector_valid high for exactly one clock.
- R4: The mask word (wr_sel = 0) loads bit i of wr_data into mask bit i, and a set bit blocks only level i. In a master instance, mask bit 2 therefore blocks the cascaded slave on line 2.
- R5: With special masking off, a level in service blocks grants of its own level and of every higher-numbered level.
- R6: A non-specific end-of-service (wr_sel = 1, wr_data[3] = 0) clears the lowest-numbered in-service bit.
- R7: A specific end-of-service (wr_sel = 1, wr_data[3] = 1) clears the in-service bit of level wr_data[2:0], whatever other bits are set.
- R8: A mode word (wr_sel = 2) with wr_data[1] = 1 loads wr_data[0] into the special-mask flag. With wr_data[1] = 0, the word leaves the flag unchanged.
- R9: With special masking on, any unmasked pending level that is not itself in service is granted, even while a higher-priority level is in service.
- R10: With special masking on, a non-specific end-of-service passes over every in-service bit whose mask bit is set.
- R11: In a master instance with automatic end-of-service on (wr_sel = 3, wr_data[0] = 1, base in wr_data[7:3]), the serviced level leaves service on the falling edge of the second acknowledge pulse.
- R12: A slave-role instance ignores the automatic end-of-service enable, and its serviced level stays in service until a command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| wr_en | input | 1 | Command write strobe |
| wr_sel | input | 2 | Word kind: 0 mask, 1 end-of-service, 2 mode, 3 configuration |
| wr_data | input | 8 | Command word |
| inta | input | 1 | Acknowledge pulse input from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| vector_out | output | 8 | Vector returned on the second acknowledge pulse |
| vector_valid | output | 1 | One-clock strobe marking vector_out |

## Verification
The in-service register has no read path, so a wrong in-service bit shows only as a wrong interrupt output: a lower request either stays silent or appears when it should not. The bench probes this by pulsing a lower-priority line right after each command and reading the interrupt output one clock later. A pending bit lost or kept in error shows up as a wrong vector on the next acknowledge, or as an interrupt output that stays high after a full drain. Exhaustive sweeps over every request pattern and every mask word compare each vector with the lowest eligible level worked out in the bench.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

   typedef enum logic [1:0] {
      WK_MASK = 2'd0,
      WK_EOI  = 2'd1,
      WK_MODE = 2'd2,
      WK_CFG  = 2'd3
   } wr_kind_e;

   typedef enum logic [1:0] {
      AK_IDLE   = 2'd0,
      AK_FIRST  = 2'd1,
      AK_SECOND = 2'd2
   } ack_phase_e;

endpackage

// File: rtl/intc_pick_first.sv
module intc_pick_first #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input  logic [W-1:0]  req,
   output logic [W-1:0]  onehot,
   output logic [IW-1:0] idx,
   output logic          any
);

   always_comb begin
      onehot = '0;
      idx    = '0;
      any    = 1'b0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req[i]) begin
            onehot    = '0;
            onehot[i] = 1'b1;
            idx       = IW'(i);
            any       = 1'b1;
         end
      end
   end

endmodule

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
   parameter int N_LVL = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] lines,
   input  logic [N_LVL-1:0] clr_oh,
   output logic [N_LVL-1:0] irr
);

   logic [N_LVL-1:0] lines_q;
   logic [N_LVL-1:0] rise;

   assign rise = lines & ~lines_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lines_q <= '0;
         irr     <= '0;
      end else begin
         lines_q <= lines;
         irr     <= (irr & ~clr_oh) | rise;
      end
   end

endmodule

// File: rtl/intc_resolver.sv
module intc_resolver #(
   parameter int N_LVL = 8,
   parameter int LVL_W = 3
) (
   input  logic [N_LVL-1:0] irr,
   input  logic [N_LVL-1:0] imr,
   input  logic [N_LVL-1:0] isr,
   input  logic             smm_on,
   output logic [N_LVL-1:0] win_oh,
   output logic [LVL_W-1:0] win_idx,
   output logic             win_any
);

   logic [N_LVL-1:0] held_off;
   logic [N_LVL-1:0] eligible;
   logic             seen;

   // held_off[i] is set when any level 0..i is in service
   always_comb begin
      seen = 1'b0;
      for (int i = 0; i < N_LVL; i++) begin
         seen        = seen | isr[i];
         held_off[i] = seen;
      end
   end

   always_comb begin
      eligible = irr & ~imr & ~isr;
      if (!smm_on) eligible = eligible & ~held_off;
   end

   intc_pick_first #(.W(N_LVL), .IW(LVL_W)) u_pick (
      .req    (eligible),
      .onehot (win_oh),
      .idx    (win_idx),
      .any    (win_any)
   );

endmodule

// File: rtl/intc_ack_seq.sv
module intc_ack_seq
   import prio_intc_pkg::*;
#(
   parameter int N_LVL = 8,
   parameter int LVL_W = 3,
   parameter int VEC_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inta,
   input  logic [N_LVL-1:0]   win_oh,
   input  logic [LVL_W-1:0]   win_idx,
   input  logic               win_any,
   input  logic [VEC_W-LVL_W-1:0] base_hi,
   output logic [N_LVL-1:0]   take_oh,
   output logic [VEC_W-1:0]   vector_out,
   output logic               vector_valid,
   output logic               final_fall
);

   localparam logic [LVL_W-1:0] SPURIOUS = LVL_W'(N_LVL - 1);

   ack_phase_e       phase;
   logic             inta_q;
   logic             rise;
   logic             fall;
   logic [LVL_W-1:0] lvl_q;

   assign rise       = inta & ~inta_q;
   assign fall       = ~inta & inta_q;
   assign final_fall = fall && (phase == AK_SECOND);
   assign take_oh    = (rise && phase != AK_FIRST && win_any) ? win_oh : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= AK_IDLE;
         inta_q       <= 1'b0;
         lvl_q        <= '0;
         vector_out   <= '0;
         vector_valid <= 1'b0;
      end else begin
         inta_q       <= inta;
         vector_valid <= 1'b0;
         if (rise) begin
            if (phase == AK_FIRST) begin
               vector_out   <= {base_hi, lvl_q};
               vector_valid <= 1'b1;
               phase        <= AK_SECOND;
            end else begin
               lvl_q <= win_any ? win_idx : SPURIOUS;
               phase <= AK_FIRST;
            end
         end else if (final_fall) begin
            phase <= AK_IDLE;
         end
      end
   end

endmodule

// File: rtl/intc_svc_reg.sv
module intc_svc_reg #(
   parameter int N_LVL = 8,
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] set_oh,
   input  logic             ns_req,
   input  logic             sp_req,
   input  logic [LVL_W-1:0] sp_lvl,
   input  logic             smm_on,
   input  logic [N_LVL-1:0] imr,
   output logic [N_LVL-1:0] isr
);

   logic [N_LVL-1:0] cand;
   logic [N_LVL-1:0] ns_oh;
   logic [LVL_W-1:0] ns_idx;
   logic             ns_any;
   logic [N_LVL-1:0] clr;

   assign cand = smm_on ? (isr & ~imr) : isr;

   intc_pick_first #(.W(N_LVL), .IW(LVL_W)) u_pick (
      .req    (cand),
      .onehot (ns_oh),
      .idx    (ns_idx),
      .any    (ns_any)
   );

   always_comb begin
      clr = '0;
      if (ns_req && ns_any) clr = clr | ns_oh;
      if (sp_req)           clr[sp_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr <= '0;
      else        isr <= (isr & ~clr) | set_oh;
   end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int N_LVL     = 8,
   parameter int VEC_W     = 8,
   parameter bit IS_MASTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_LVL-1:0] irq_in,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [VEC_W-1:0] wr_data,
   input  logic             inta,
   output logic             int_out,
   output logic [VEC_W-1:0] vector_out,
   output logic             vector_valid
);

   localparam int LVL_W  = $clog2(N_LVL);
   localparam int BASE_W = VEC_W - LVL_W;

   generate
      if (N_LVL < 2 || (1 << LVL_W) != N_LVL) begin : g_bad_lvl
         $error("N_LVL must be a power of two, at least 2");
      end
      if (VEC_W < N_LVL || VEC_W < LVL_W + 1 || VEC_W < 2) begin : g_bad_vec
         $error("VEC_W too narrow for mask word or command fields");
      end
   endgenerate

   logic [N_LVL-1:0]  imr_q;
   logic              smm_q;
   logic              aeoi_cfg_q;
   logic              aeoi_eff;
   logic [BASE_W-1:0] base_hi_q;
   logic [N_LVL-1:0]  irr_q;
   logic [N_LVL-1:0]  isr_q;
   logic [N_LVL-1:0]  win_oh;
   logic [LVL_W-1:0]  win_idx;
   logic              win_any;
   logic [N_LVL-1:0]  take_oh;
   logic              final_fall;
   logic              wr_eoi;
   logic              eoi_ns;
   logic              eoi_sp;

   // command register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q      <= '1;
         smm_q      <= 1'b0;
         aeoi_cfg_q <= 1'b0;
         base_hi_q  <= '0;
      end else if (wr_en) begin
         case (wr_kind_e'(wr_sel))
            WK_MASK: imr_q <= wr_data[N_LVL-1:0];
            WK_MODE: if (wr_data[1]) smm_q <= wr_data[0];
            WK_CFG: begin
               aeoi_cfg_q <= wr_data[0];
               base_hi_q  <= wr_data[VEC_W-1:LVL_W];
            end
            default: ;
         endcase
      end
   end

   assign wr_eoi = wr_en && (wr_kind_e'(wr_sel) == WK_EOI);
   assign eoi_sp = wr_eoi &&  wr_data[LVL_W];
   assign eoi_ns = (wr_eoi && !wr_data[LVL_W]) || (aeoi_eff && final_fall);

   // automatic end-of-service exists only in the master role
   generate
      if (IS_MASTER) begin : g_master
         assign aeoi_eff = aeoi_cfg_q;
      end else begin : g_slave
         assign aeoi_eff = 1'b0;
      end
   endgenerate

   intc_req_latch #(.N_LVL(N_LVL)) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .lines  (irq_in),
      .clr_oh (take_oh),
      .irr    (irr_q)
   );

   intc_resolver #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_res (
      .irr     (irr_q),
      .imr     (imr_q),
      .isr     (isr_q),
      .smm_on  (smm_q),
      .win_oh  (win_oh),
      .win_idx (win_idx),
      .win_any (win_any)
   );

   intc_ack_seq #(.N_LVL(N_LVL), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
      .clk          (clk),
      .rst_n        (rst_n),
      .inta         (inta),
      .win_oh       (win_oh),
      .win_idx      (win_idx),
      .win_any      (win_any),
      .base_hi      (base_hi_q),
      .take_oh      (take_oh),
      .vector_out   (vector_out),
      .vector_valid (vector_valid),
      .final_fall   (final_fall)
   );

   intc_svc_reg #(.N_LVL(N_LVL), .LVL_W(LVL_W)) u_svc (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_oh (take_oh),
      .ns_req (eoi_ns),
      .sp_req (eoi_sp),
      .sp_lvl (wr_data[LVL_W-1:0]),
      .smm_on (smm_q),
      .imr    (imr_q),
      .isr    (isr_q)
   );

   assign int_out = win_any;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
   parameter int N_LVL = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_LVL-1:0] irr,
   input logic [N_LVL-1:0] isr,
   input logic [N_LVL-1:0] imr,
   input logic [N_LVL-1:0] win,
   input logic             smm_on,
   input logic             int_out
);

   localparam logic [N_LVL-1:0] ONE = N_LVL'(1);

   logic [N_LVL-1:0] isr_top;
   logic [N_LVL-1:0] blocked;

   assign isr_top = isr & (~isr + ONE);
   assign blocked = ~(isr_top - ONE);

   // R4
   mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win & imr) == '0);

   // R2
   no_spurious_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irr & ~imr) == '0) |-> !int_out);

   // R5
   nested_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smm_on && isr != '0) |-> ((win & blocked) == '0));

   // R3
   one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr & ~$past(isr)));

   // R6
   one_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0($past(isr) & ~isr));

endmodule

bind prio_intc prio_intc_chk #(.N_LVL(N_LVL)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irr     (irr_q),
   .isr     (isr_q),
   .imr     (imr_q),
   .win     (win_oh),
   .smm_on  (smm_q),
   .int_out (int_out)
);

// File: tb/prio_intc_tb.sv
module prio_intc_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       inta = 1'b0;
   logic       int_out, vv;
   logic [7:0] vec;
   logic       s_int, s_vv;
   logic [7:0] s_vec;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   prio_intc u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .inta(inta), .int_out(int_out), .vector_out(vec),
      .vector_valid(vv));

   prio_intc #(.IS_MASTER(1'b0)) u_dut_slv (
      .clk(clk), .rst_n(rst_n), .irq_in(irq), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .inta(inta), .int_out(s_int), .vector_out(s_vec),
      .vector_valid(s_vv));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] k, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = k; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_irq(input logic [7:0] m);
      irq = m;
      @(negedge clk);
      irq = '0;
      @(negedge clk);
   endtask

   task automatic eoi_ns();
      wr(2'd1, 8'h00);
   endtask

   task automatic eoi_sp(input int l);
      wr(2'd1, 8'h08 | 8'(l));
   endtask

   task automatic ack(output logic [7:0] v, output logic valid);
      inta = 1'b1; @(negedge clk);
      inta = 1'b0; @(negedge clk);
      inta = 1'b1; @(negedge clk);
      v = vec; valid = vv;
      inta = 1'b0; @(negedge clk);
   endtask

   function automatic int lowest(input logic [7:0] m);
      for (int i = 7; i >= 0; i--) if (m[i]) lowest = i;
   endfunction

   // serve every level of pend in priority order, checking each vector
   task automatic serve(input logic [7:0] pend, input int base, input string req);
      logic [7:0] v;
      logic       ok;
      logic [7:0] rem = pend;
      while (rem != 0) begin
         int e = lowest(rem);
         chk({req, " int"}, int'(int_out), 1);
         ack(v, ok);
         chk({req, " vec"}, int'(v), base + e);
         chk({req, " valid"}, int'(ok), 1);
         eoi_ns();
         rem[e] = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual expired expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic       ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 int", int'(int_out), 0);
      chk("R1 valid", int'(vv), 0);
      pulse_irq(8'hFF);
      chk("R1 all masked", int'(int_out), 0);
      // R2 pending bits kept after lines fall; unmask and drain in order
      wr(2'd0, 8'h00);
      chk("R2 latched", int'(int_out), 1);
      serve(8'hFF, 0, "R2");
      chk("R2 drained", int'(int_out), 0);

      // R3 exhaustive request patterns
      for (int p = 1; p < 256; p++) begin
         pulse_irq(8'(p));
         serve(8'(p), 0, "R3");
         chk("R3 empty", int'(int_out), 0);
      end

      // R3 vector valid is a single clock
      pulse_irq(8'h10);
      inta = 1'b1; @(negedge clk); inta = 1'b0; @(negedge clk);
      inta = 1'b1; @(negedge clk);
      chk("R3 vv first", int'(vv), 1);
      inta = 1'b0; @(negedge clk);
      chk("R3 vv one clock", int'(vv), 0);
      eoi_ns();

      // R4 exhaustive mask words
      for (int m = 0; m < 256; m++) begin
         wr(2'd0, 8'(m));
         pulse_irq(8'hFF);
         serve(~8'(m), 0, "R4 unmasked");
         chk("R4 masked silent", int'(int_out), 0);
         wr(2'd0, 8'h00);
         serve(8'(m), 0, "R4 release");
      end

      // R4 cascade line of master
      wr(2'd0, 8'h04);
      pulse_irq(8'h04);
      chk("R4 cascade blocked", int'(int_out), 0);
      wr(2'd0, 8'h00);
      serve(8'h04, 0, "R4 cascade");

      // R5 / R6 nesting, R8 ignored mode word
      pulse_irq(8'h20); ack(v, ok); chk("R5 vec5", int'(v), 5);
      pulse_irq(8'h40);
      chk("R5 lower blocked", int'(int_out), 0);
      pulse_irq(8'h20);
      chk("R5 same blocked", int'(int_out), 0);
      wr(2'd2, 8'h01);
      chk("R8 no-enable word ignored", int'(int_out), 0);
      pulse_irq(8'h08);
      chk("R5 higher granted", int'(int_out), 1);
      ack(v, ok); chk("R5 vec3", int'(v), 3);
      eoi_ns();
      chk("R6 cleared highest only", int'(int_out), 0);
      eoi_ns();
      serve(8'h60, 0, "R6");
      chk("R6 empty", int'(int_out), 0);

      // R7 specific end-of-service
      pulse_irq(8'h20); ack(v, ok);
      pulse_irq(8'h04); ack(v, ok); chk("R7 vec2", int'(v), 2);
      eoi_sp(5);
      pulse_irq(8'h40);
      chk("R7 level2 still holds", int'(int_out), 0);
      eoi_sp(2);
      chk("R7 both cleared", int'(int_out), 1);
      serve(8'h40, 0, "R7");

      // R8 / R9 / R10 special masking
      wr(2'd2, 8'h03);
      pulse_irq(8'h08); ack(v, ok); chk("R9 vec3", int'(v), 3);
      pulse_irq(8'h40);
      chk("R9 granted under higher", int'(int_out), 1);
      ack(v, ok); chk("R9 vec6", int'(v), 6);
      wr(2'd0, 8'h08);
      eoi_ns();
      wr(2'd0, 8'h00);
      pulse_irq(8'h40);
      chk("R10 masked level skipped", int'(int_out), 1);
      ack(v, ok); chk("R10 vec6", int'(v), 6);
      wr(2'd2, 8'h02);
      pulse_irq(8'h10);
      chk("R8 special mask left", int'(int_out), 0);
      eoi_ns();
      chk("R6 level3 retired", int'(int_out), 1);
      ack(v, ok); chk("R6 vec4", int'(v), 4);
      eoi_ns(); eoi_ns();
      chk("R10 empty", int'(int_out), 0);

      // R11 / R12 automatic end-of-service
      wr(2'd3, 8'h21);
      pulse_irq(8'h20); ack(v, ok);
      chk("R11 base vec", int'(v), 8'h25);
      chk("R12 slave vec", int'(s_vec), 8'h25);
      pulse_irq(8'h40);
      chk("R11 master auto retired", int'(int_out), 1);
      chk("R12 slave still holds", int'(s_int), 0);
      wr(2'd3, 8'h20);
      eoi_ns();
      chk("R12 slave after command", int'(s_int), 1);
      serve(8'h40, 8'h20, "R11");
      chk("R11 empty", int'(int_out), 0);
      chk("R12 empty", int'(s_int), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule